// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block takes the raw sample stream of a data converter core and turns it into the word that leaves the chip. Each sample arrives with a one-cycle strobe and two overdrive flags. The core always delivers its samples in offset binary. The block passes the sample on in offset binary or in two's complement. An overdriven sample is replaced by the full-scale code of the selected format. For bring-up and board test, the live sample can be replaced by a built-in pattern: constant zeros, constant ones, a bit-alternating toggle word, an incrementing ramp, or a fixed word assembled from two configuration bytes.

A small state machine decides the source of every strobed sample. Its state records the source used for the previous strobed sample. The states are LIVE, ZERO, ONES, TOGGLE, RAMP and CUSTOM. On every strobe the state takes the value decoded from the pattern select. This gives three kinds of transition:
- A strobe that moves the state into TOGGLE or RAMP from any other state seeds that pattern. This is the "enter" transition.
- A strobe that keeps the state in TOGGLE or RAMP advances that pattern by one step. This is the "stay" transition.
- A cycle without a strobe leaves the state and both pattern registers untouched. This is the "hold" transition.

The output word, its strobe and an out-of-range flag are registered. They appear one clock after the sample strobe.

Top module: `sample_out_formatter`

## Requirements
- R1: While reset (`rst_n` low) is applied and after its release with no strobe yet, `out_word` is 0x0000, `out_vld` is 0 and `out_ovr` is 0.
- R2: `out_vld` is high exactly in the cycle after a cycle with `smp_vld` high. In cycles without a strobe, `out_word` and `out_ovr` keep their last values, whatever the other inputs do.
- R3: With pattern select 000 and no overdrive, `fmt_ob`=1 (offset binary) passes `smp_data` unchanged. `fmt_ob`=0 (two's complement) outputs `smp_data` with its most significant bit inverted. `out_ovr` is 0.
- R4: A live sample with `ovr_pos` set is output as 0xFFFF when `fmt_ob`=1 and as 0x7FFF when `fmt_ob`=0, with `out_ovr`=1.
- R5: A live sample with `ovr_neg` set is output as 0x0000 when `fmt_ob`=1 and as 0x8000 when `fmt_ob`=0, with `out_ovr`=1. If both flags are set, the positive clamp wins.
- R6: Pattern select 001 outputs 0x0000, 010 outputs 0xFFFF, and 101 outputs {`cust_hi`,`cust_lo`} (high byte in bits 15:8). In all three, `fmt_ob`, the overdrive flags and the sample are ignored and `out_ovr` is 0.
- R7: Pattern select 011 (toggle) outputs 0xAAAA on the first strobe after entering from another source. Each further strobe outputs the bitwise inverse of the previous toggle word (0x5555, 0xAAAA, ...). `out_ovr` is 0.
- R8: Pattern select 100 (ramp) outputs 0x0000 on the first strobe after entering from another source. Each further strobe outputs the previous value plus one, wrapping from 0xFFFF to 0x0000. `out_ovr` is 0.
- R9: Pattern select codes 110 and 111 behave exactly like 000 (live data with format and clamp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one per converted sample |
| smp_data | input | 16 | Raw sample from the core, offset binary |
| ovr_pos | input | 1 | Sample exceeds the positive full scale |
| ovr_neg | input | 1 | Sample exceeds the negative full scale |
| fmt_ob | input | 1 | Output format: 1 offset binary, 0 two's complement |
| pat_sel | input | 3 | Source select: 000 live, 001 zeros, 010 ones, 011 toggle, 100 ramp, 101 custom, 110/111 live |
| cust_lo | input | 8 | Custom word, bits 7:0 |
| cust_hi | input | 8 | Custom word, bits 15:8 |
| out_word | output | 16 | Formatted output word |
| out_vld | output | 1 | Output word strobe |
| out_ovr | output | 1 | Out-of-range indicator for the current word |

## Verification
Every result is due exactly one clock after the strobe that carried its sample: `out_word`, `out_ovr` and `out_vld` are all set by the same register stage. The driver applies inputs on the falling edge and queues the expected word at that moment. The monitor compares `out_vld`, `out_word` and `out_ovr` shortly after the next rising edge, so each queued item meets the output one register later. Hold behaviour is checked after idle gaps in which the other inputs are changed. The toggle and ramp sequences are followed strobe by strobe, and the ramp is run through a full wrap and a re-entry.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    typedef enum logic [2:0] {
        SRC_LIVE   = 3'd0,
        SRC_ZERO   = 3'd1,
        SRC_ONES   = 3'd2,
        SRC_TOGGLE = 3'd3,
        SRC_RAMP   = 3'd4,
        SRC_CUSTOM = 3'd5
    } src_state_e;

    // Maps the select field to a source; the spare codes fall back to live data.
    function automatic src_state_e decode_sel(input logic [2:0] sel);
        src_state_e s;
        unique case (sel)
            3'd1:    s = SRC_ZERO;
            3'd2:    s = SRC_ONES;
            3'd3:    s = SRC_TOGGLE;
            3'd4:    s = SRC_RAMP;
            3'd5:    s = SRC_CUSTOM;
            default: s = SRC_LIVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ofmt_live_path.sv
module ofmt_live_path #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         pos_ovr,
    input  logic         neg_ovr,
    input  logic         fmt_ob,
    output logic [W-1:0] word,
    output logic         range_hit
);
    localparam logic [W-1:0] OB_MAX = {W{1'b1}};
    localparam logic [W-1:0] OB_MIN = {W{1'b0}};
    localparam logic [W-1:0] TC_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] TC_MIN = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        range_hit = pos_ovr | neg_ovr;
        if (pos_ovr) begin
            word = fmt_ob ? OB_MAX : TC_MAX;
        end else if (neg_ovr) begin
            word = fmt_ob ? OB_MIN : TC_MIN;
        end else if (fmt_ob) begin
            word = raw;
        end else begin
            word = {~raw[W-1], raw[W-2:0]};
        end
    end

endmodule

// File: rtl/ofmt_pattern_fsm.sv
module ofmt_pattern_fsm
    import ofmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [2:0]     pat_sel,
    input  logic [W/2-1:0] cust_hi,
    input  logic [W/2-1:0] cust_lo,
    output src_state_e     src_now,
    output logic [W-1:0]   pat_word
);
    localparam int HALF = W / 2;

    // Seed word of the toggle pattern: odd bit positions set.
    function automatic logic [W-1:0] toggle_seed();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) begin
            v[i] = (i % 2) == 1;
        end
        return v;
    endfunction

    localparam logic [W-1:0] TOG_SEED = toggle_seed();

    src_state_e   state_q;
    logic [W-1:0] ramp_q;
    logic [W-1:0] tog_q;

    assign src_now = decode_sel(pat_sel);

    // State register and pattern registers move only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_LIVE;
            ramp_q  <= '0;
            tog_q   <= '0;
        end else if (adv) begin
            state_q <= src_now;
            if (src_now == SRC_RAMP) begin
                ramp_q <= pat_word + W'(1);
            end
            if (src_now == SRC_TOGGLE) begin
                tog_q <= pat_word;
            end
        end
    end

    // Pattern word for the sample now being strobed.
    always_comb begin
        unique case (src_now)
            SRC_ZERO:   pat_word = '0;
            SRC_ONES:   pat_word = '1;
            SRC_CUSTOM: pat_word = {cust_hi[HALF-1:0], cust_lo[HALF-1:0]};
            SRC_TOGGLE: pat_word = (state_q == SRC_TOGGLE) ? ~tog_q : TOG_SEED;
            SRC_RAMP:   pat_word = (state_q == SRC_RAMP) ? ramp_q : '0;
            default:    pat_word = '0;
        endcase
    end

    // R7
    toggle_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (src_now == SRC_TOGGLE) && (state_q != SRC_TOGGLE) |=> tog_q == TOG_SEED);

    // R8
    ramp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (src_now == SRC_RAMP) && (state_q != SRC_RAMP) |=> ramp_q == W'(1));

endmodule

// File: rtl/sample_out_formatter.sv
module sample_out_formatter
    import ofmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [W-1:0]   smp_data,
    input  logic           ovr_pos,
    input  logic           ovr_neg,
    input  logic           fmt_ob,
    input  logic [2:0]     pat_sel,
    input  logic [W/2-1:0] cust_lo,
    input  logic [W/2-1:0] cust_hi,
    output logic [W-1:0]   out_word,
    output logic           out_vld,
    output logic           out_ovr
);
    localparam logic [W-1:0] OB_MAX = {W{1'b1}};
    localparam logic [W-1:0] TC_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] TC_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] live_word;
    logic         live_hit;
    logic [W-1:0] pat_word;
    src_state_e   src_now;

    ofmt_live_path #(.W(W)) u_live (
        .raw       (smp_data),
        .pos_ovr   (ovr_pos),
        .neg_ovr   (ovr_neg),
        .fmt_ob    (fmt_ob),
        .word      (live_word),
        .range_hit (live_hit)
    );

    ofmt_pattern_fsm #(.W(W)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (smp_vld),
        .pat_sel  (pat_sel),
        .cust_hi  (cust_hi),
        .cust_lo  (cust_lo),
        .src_now  (src_now),
        .pat_word (pat_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_vld  <= 1'b0;
            out_ovr  <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                out_word <= (src_now == SRC_LIVE) ? live_word : pat_word;
                out_ovr  <= (src_now == SRC_LIVE) && live_hit;
            end
        end
    end

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !out_vld && $stable(out_word) && $stable(out_ovr));

    // R4
    ovr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovr |-> (out_word == OB_MAX) || (out_word == '0)
                    || (out_word == TC_MAX) || (out_word == TC_MIN));

    // R6
    pattern_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (src_now != SRC_LIVE) |=> !out_ovr);

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && src_now == SRC_TOGGLE) ##1 (smp_vld && src_now == SRC_TOGGLE)
        |=> out_word == ~$past(out_word));

    // R8
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && src_now == SRC_RAMP) ##1 (smp_vld && src_now == SRC_RAMP)
        |=> out_word == $past(out_word) + W'(1));

endmodule

// File: tb/sample_out_formatter_tb.sv
module sample_out_formatter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         ovr_pos = 1'b0;
    logic         ovr_neg = 1'b0;
    logic         fmt_ob = 1'b0;
    logic [2:0]   pat_sel = 3'd0;
    logic [7:0]   cust_lo = 8'h00;
    logic [7:0]   cust_hi = 8'h00;
    logic [W-1:0] out_word;
    logic         out_vld;
    logic         out_ovr;

    int checks = 0;
    int fails = 0;

    logic [W-1:0] qw[$];
    logic         qo[$];
    string        qt[$];

    // Bench reference state
    int           m_prev = 0;
    logic [W-1:0] m_ramp = '0;
    logic [W-1:0] m_tog = '0;
    logic [W-1:0] m_last_w = '0;
    logic         m_last_o = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_out_formatter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .ovr_pos(ovr_pos), .ovr_neg(ovr_neg), .fmt_ob(fmt_ob), .pat_sel(pat_sel),
        .cust_lo(cust_lo), .cust_hi(cust_hi),
        .out_word(out_word), .out_vld(out_vld), .out_ovr(out_ovr)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mode_of(input logic [2:0] s);
        return (s >= 3'd1 && s <= 3'd5) ? int'(s) : 0;
    endfunction

    // Drive one strobed sample and queue its expected result.
    task automatic send(input logic [W-1:0] d, input logic p, input logic n,
                        input logic f, input logic [2:0] s, input string tag);
        int md;
        logic [W-1:0] ew;
        logic eo;
        @(negedge clk);
        md = mode_of(s);
        eo = 1'b0;
        case (md)
            1: ew = 16'h0000;
            2: ew = 16'hFFFF;
            3: begin ew = (m_prev == 3) ? ~m_tog : 16'hAAAA; m_tog = ew; end
            4: begin ew = (m_prev == 4) ? m_ramp : 16'h0000; m_ramp = ew + 16'd1; end
            5: ew = {cust_hi, cust_lo};
            default: begin
                if (p)      begin ew = f ? 16'hFFFF : 16'h7FFF; eo = 1'b1; end
                else if (n) begin ew = f ? 16'h0000 : 16'h8000; eo = 1'b1; end
                else        ew = f ? d : (d ^ 16'h8000);
            end
        endcase
        m_prev = md;
        m_last_w = ew;
        m_last_o = eo;
        qw.push_back(ew);
        qo.push_back(eo);
        qt.push_back(tag);
        smp_vld = 1'b1; smp_data = d; ovr_pos = p; ovr_neg = n; fmt_ob = f; pat_sel = s;
    endtask

    // Idle cycles with noisy inputs, then check the outputs held (R2).
    task automatic idle_hold(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            smp_vld = 1'b0;
            smp_data = smp_data + 16'h1357;
            ovr_pos = ~ovr_pos;
            pat_sel = pat_sel + 3'd1;
            fmt_ob = ~fmt_ob;
        end
        @(negedge clk);
        check("R2 idle out_vld", {15'd0, out_vld}, 16'd0);
        check("R2 idle out_word held", out_word, m_last_w);
        check("R2 idle out_ovr held", {15'd0, out_ovr}, {15'd0, m_last_o});
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (rst_n && out_vld) begin
            if (qw.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected out_vld actual=%h expected=none", out_word);
            end else begin
                logic [W-1:0] ew;
                logic eo;
                string t;
                ew = qw.pop_front();
                eo = qo.pop_front();
                t = qt.pop_front();
                check({t, " word"}, out_word, ew);
                check({t, " ovr"}, {15'd0, out_ovr}, {15'd0, eo});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_word", out_word, 16'h0000);
        check("R1 reset out_vld", {15'd0, out_vld}, 16'd0);
        check("R1 reset out_ovr", {15'd0, out_ovr}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release out_word", out_word, 16'h0000);
        check("R1 after release out_vld", {15'd0, out_vld}, 16'd0);

        // R3 live formats
        send(16'h1234, 0, 0, 1, 3'd0, "R3 offset pass");
        send(16'h1234, 0, 0, 0, 3'd0, "R3 twos msb flip");
        send(16'hF00F, 0, 0, 0, 3'd0, "R3 twos high");
        send(16'h8000, 0, 0, 1, 3'd0, "R3 offset mid");
        // R4 / R5 clamps
        send(16'h0001, 1, 0, 1, 3'd0, "R4 pos offset");
        send(16'h0001, 1, 0, 0, 3'd0, "R4 pos twos");
        send(16'hFFFE, 0, 1, 1, 3'd0, "R5 neg offset");
        send(16'hFFFE, 0, 1, 0, 3'd0, "R5 neg twos");
        send(16'h4444, 1, 1, 0, 3'd0, "R5 both flags pos wins");
        idle_hold(3);

        // R6 fixed patterns
        cust_hi = 8'hC3; cust_lo = 8'h5A;
        send(16'h7777, 1, 0, 0, 3'd1, "R6 zeros");
        send(16'h7777, 0, 1, 1, 3'd2, "R6 ones");
        send(16'h7777, 1, 0, 0, 3'd5, "R6 custom");
        // R9 spare codes
        send(16'h2222, 0, 0, 0, 3'd6, "R9 code6 live");
        send(16'h2222, 0, 1, 1, 3'd7, "R9 code7 clamp");

        // R7 toggle, with hold gap and re-entry
        send(16'h0, 1, 0, 0, 3'd3, "R7 toggle seed");
        send(16'h0, 0, 0, 0, 3'd3, "R7 toggle 2");
        send(16'h0, 0, 0, 0, 3'd3, "R7 toggle 3");
        idle_hold(2);
        send(16'h0, 0, 0, 0, 3'd3, "R7 toggle after gap");
        send(16'h0, 0, 0, 0, 3'd2, "R6 ones between");
        send(16'h0, 0, 0, 0, 3'd3, "R7 toggle reentry");

        // R8 ramp through a full wrap, then re-entry
        for (int i = 0; i < 65540; i++) begin
            send(16'h0, 0, 0, 1, 3'd4, "R8 ramp");
        end
        send(16'h0, 0, 0, 0, 3'd0, "R3 live between ramps");
        send(16'h0, 0, 0, 0, 3'd4, "R8 ramp reentry");
        send(16'h0, 0, 0, 0, 3'd4, "R8 ramp reentry step");
        idle_hold(2);

        if (qw.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2 missing outputs actual=%0d expected=0", qw.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule